// File: doc/BRIEF.md
# Dual-Source CPU Clock Controller

This block decides which oscillator clocks the processor and at what rate. There are two sources: a fast main oscillator, whose cycles are the block's own `clk`, and a slow subsystem oscillator. The subsystem oscillator is presented as a one-cycle `sub_tick` pulse per subsystem period, together with a `sub_ready` level. The controller does not gate a clock. It emits `cpu_ce`, a one-cycle clock-enable strobe that the processor core samples.

After reset the main oscillator must settle before the core may run. A saturating counter of 2^`SETTLE_W` main cycles enforces this wait, and then the core starts in slow mode. Software controls the block through a byte-wide write port with two registers:

- The processor control register (address 0) holds an oscillator-stop bit and a speed bit.
- The source register (address 1) holds the source-select bit.

The block refuses writes that would stop the oscillator under the running core, and writes that would return the core to an oscillator that is not settled. A power-supply monitor outside the block interrupts software, and software then makes these switches. The block has no data stream, so there is no valid/ready handshake or back-pressure. Every pin is a plain control or status level, and a write takes effect on the clock edge where `wr_en` is high.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: `main_ready` rises exactly 2^SETTLE_W clock edges after reset release, or after the stop bit returns to 0. It then stays high until the oscillator is stopped.
- R2: While the main source is active and `main_ready` is low, `cpu_ce` stays low.
- R3: After settling, with the speed bit at 0, `cpu_ce` pulses once every SLOW_DIV cycles (default 8). The first pulse comes SLOW_DIV cycles after `main_ready` rises.
- R4: With the speed bit (address 0, bit 1) at 1 and the main source active, `cpu_ce` pulses once every FAST_DIV cycles (default 2).
- R5: Writing 1 to the source bit (address 1, bit 4) is accepted only while `sub_ready` is high. Once that bit is active, `cpu_ce` follows `sub_tick`, delayed by one cycle.
- R6: While the stop bit (address 0, bit 7) is 1, `main_osc_en` is low. `main_ready` falls on the edge after the stop bit is set.
- R7: Writing 0 to the source bit is ignored while the oscillator is stopped or still settling.
- R8: Writing 1 to the stop bit is ignored unless the source register selects the subsystem source and that source is already active.
- R9: Reset clears all register bits. This selects the main source and slow mode with the oscillator running, and drives `cpu_ce` low.
- R10: The active source and speed change only on the cycle in which `cpu_ce` is high, so no clock-enable period is ever cut short.
- R11: The readback ports show the stop bit at bit 7 and the speed bit at bit 1 of `pcc_rd`, and the source bit at bit 4 of `css_rd`. All other readback bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-cycle pulse per subsystem oscillator period |
| sub_ready | input | 1 | Subsystem oscillator settled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the processor control register, 1 selects the source register |
| wr_data | input | 8 | Write data |
| cpu_ce | output | 1 | Processor clock-enable strobe |
| main_osc_en | output | 1 | Enable to the main oscillator |
| main_ready | output | 1 | Main oscillator settling complete |
| on_sub | output | 1 | Subsystem source is active |
| fast_active | output | 1 | Fast main rate is active |
| pcc_rd | output | 8 | Processor control register readback |
| css_rd | output | 8 | Source register readback |

## Verification
Each output is due at a fixed cycle:

- Register readback changes on the write edge itself.
- `main_ready` falls one edge after the stop bit is set, and rises 2^SETTLE_W edges after the bit clears.
- `cpu_ce` is registered, so it appears one cycle after the divider reaches its limit or after `sub_tick`.
- The active source and speed flip on that same edge.

The bench keeps a behavioural model that steps on each rising edge from the inputs it drove at the falling edge. It compares every output at the next falling edge, so each output is judged in exactly the cycle it is due. Directed checks then count strobes over windows that are whole multiples of the divide ratio.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_SUB  = 1'b1
  } clk_src_e;

  localparam int STOP_BIT  = 7;
  localparam int SPEED_BIT = 1;
  localparam int SRC_BIT   = 4;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SRC  = 1'b1;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_stop,
  output logic main_ready
);
  localparam int CW = SETTLE_W + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (osc_stop) begin
      cnt_q <= '0;
    end else if (!cnt_q[CW-1]) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign main_ready = cnt_q[CW-1];

  // R6
  stop_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> !main_ready);

  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ready && !osc_stop) |=> main_ready);
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import cpu_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       main_ready,
  input  logic       sub_ready,
  input  clk_src_e   act_src,
  output logic       stop_q,
  output logic       speed_q,
  output logic       src_q
);
  logic ctrl_we, src_we;
  logic stop_ok, src_ok;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign src_we  = wr_en && (wr_addr == ADDR_SRC);

  // stopping needs the subsystem source both requested and running;
  // restarting is always allowed
  assign stop_ok = !wr_data[STOP_BIT] || (src_q && (act_src == SRC_SUB));
  // each source can only be requested when it is settled
  assign src_ok  = wr_data[SRC_BIT] ? sub_ready : (main_ready && !stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      speed_q <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      if (ctrl_we) begin
        speed_q <= wr_data[SPEED_BIT];
        if (stop_ok) stop_q <= wr_data[STOP_BIT];
      end
      if (src_we && src_ok) src_q <= wr_data[SRC_BIT];
    end
  end

  // R8
  stop_only_on_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(src_q && (act_src == SRC_SUB)));

  // R7
  back_to_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_q) |-> $past(main_ready && !stop_q));

  // R5
  to_sub_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q) |-> $past(sub_ready));
endmodule

// File: rtl/ce_divider.sv
module ce_divider
  import cpu_clk_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     main_ready,
  input  logic     sub_tick,
  input  logic     sel_sub,
  input  logic     sel_fast,
  output logic     cpu_ce,
  output clk_src_e act_src,
  output logic     act_fast
);
  localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int DW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam logic [DW-1:0] FAST_LIM = DW'(FAST_DIV - 1);
  localparam logic [DW-1:0] SLOW_LIM = DW'(SLOW_DIV - 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] cur_lim;
  logic          main_hit;
  logic          tick;

  assign cur_lim  = act_fast ? FAST_LIM : SLOW_LIM;
  assign main_hit = main_ready && (div_q == cur_lim);
  assign tick     = (act_src == SRC_SUB) ? sub_tick : main_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      cpu_ce   <= 1'b0;
      act_src  <= SRC_MAIN;
      act_fast <= 1'b0;
    end else begin
      cpu_ce <= tick;
      if (tick) begin
        // pulse boundary: adopt the requested configuration
        act_src  <= sel_sub ? SRC_SUB : SRC_MAIN;
        act_fast <= sel_fast;
        div_q    <= '0;
      end else if ((act_src == SRC_MAIN) && main_ready) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R10
  switch_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_src) || !$stable(act_fast)) |-> cpu_ce);

  // R2
  no_ce_unsettled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ready && (act_src == SRC_MAIN)) |=> !cpu_ce);

  generate
    if (SLOW_DIV > 1) begin : g_slow_gap
      // R3
      slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && (act_src == SRC_MAIN) && !act_fast) |=> !cpu_ce);
    end
  endgenerate
endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import cpu_clk_pkg::*;
#(
  parameter int SETTLE_W = 15,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       sub_ready,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       cpu_ce,
  output logic       main_osc_en,
  output logic       main_ready,
  output logic       on_sub,
  output logic       fast_active,
  output logic [7:0] pcc_rd,
  output logic [7:0] css_rd
);
  logic     stop_q, speed_q, src_q;
  clk_src_e act_src;
  logic     act_fast;

  settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_stop   (stop_q),
    .main_ready (main_ready)
  );

  clk_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .main_ready (main_ready),
    .sub_ready  (sub_ready),
    .act_src    (act_src),
    .stop_q     (stop_q),
    .speed_q    (speed_q),
    .src_q      (src_q)
  );

  ce_divider #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_ready (main_ready),
    .sub_tick   (sub_tick),
    .sel_sub    (src_q),
    .sel_fast   (speed_q),
    .cpu_ce     (cpu_ce),
    .act_src    (act_src),
    .act_fast   (act_fast)
  );

  assign main_osc_en = !stop_q;
  assign on_sub      = (act_src == SRC_SUB);
  assign fast_active = act_fast && (act_src == SRC_MAIN);

  always_comb begin
    pcc_rd            = 8'h00;
    pcc_rd[STOP_BIT]  = stop_q;
    pcc_rd[SPEED_BIT] = speed_q;
    css_rd            = 8'h00;
    css_rd[SRC_BIT]   = src_q;
  end

  // R6
  osc_follows_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> on_sub);
endmodule

// File: tb/cpu_clk_ctrl_bench.sv
module cpu_clk_ctrl_bench;
  localparam int SW   = 10;
  localparam int FD   = 2;
  localparam int SD   = 8;
  localparam int NSET = 1 << SW;
  localparam int SUBP = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, sub_ready = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic cpu_ce, main_osc_en, main_ready, on_sub, fast_active;
  logic [7:0] pcc_rd, css_rd;

  always #10 clk = ~clk;

  cpu_clk_ctrl #(.SETTLE_W(SW), .FAST_DIV(FD), .SLOW_DIV(SD)) u_cpu_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .sub_ready(sub_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_ce(cpu_ce), .main_osc_en(main_osc_en), .main_ready(main_ready),
    .on_sub(on_sub), .fast_active(fast_active), .pcc_rd(pcc_rd), .css_rd(css_rd)
  );

  int total = 0, bad = 0, cyc = 0, sc = 0;
  int ce_cnt = 0, early_ce = 0;
  bit done = 0, prev_sub = 0;

  // reference model state
  int m_cnt = 0, m_div = 0;
  bit m_stop = 0, m_speed = 0, m_src = 0, m_act = 0, m_fast = 0, m_ce = 0;

  task automatic chk(string r, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always @(negedge clk) begin
    sc++;
    sub_tick = (sc % SUBP == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_stop = 0; m_speed = 0;
      m_src = 0; m_act = 0; m_fast = 0; m_ce = 0;
    end else begin
      bit rdy, tk, o_stop, o_src, o_speed;
      rdy = (m_cnt >= NSET);
      o_stop = m_stop; o_src = m_src; o_speed = m_speed;
      if (m_act) tk = sub_tick;
      else tk = rdy && (m_div == (m_fast ? FD : SD) - 1);
      m_ce = tk;
      if (tk) begin
        m_act = o_src; m_fast = o_speed; m_div = 0;
      end else if (!m_act && rdy) m_div++;
      if (o_stop) m_cnt = 0;
      else if (m_cnt < NSET) m_cnt++;
      if (wr_en && wr_addr == 1'b0) begin
        m_speed = wr_data[1];
        if (!wr_data[7] || (o_src && m_act_prev_ok(o_src))) m_stop = wr_data[7];
      end
      if (wr_en && wr_addr == 1'b1) begin
        if (wr_data[4] ? sub_ready : (rdy && !o_stop)) m_src = wr_data[4];
      end
    end
  end

  // activity of the subsystem source before this edge, kept separately
  bit act_before = 0;
  always @(negedge clk) act_before = m_act;
  function automatic bit m_act_prev_ok(bit s);
    return s && act_before;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "main_ready", main_ready, m_cnt >= NSET);
      chk("R3", "cpu_ce", cpu_ce, m_ce);
      chk("R6", "main_osc_en", main_osc_en, !m_stop);
      chk("R5", "on_sub", on_sub, m_act);
      chk("R4", "fast_active", fast_active, m_fast && !m_act);
      chk("R8", "pcc_rd", pcc_rd, {m_stop, 5'b0, m_speed, 1'b0});
      chk("R7", "css_rd", css_rd, {3'b0, m_src, 4'b0});
      if (on_sub != prev_sub) chk("R10", "cpu_ce at source switch", cpu_ce, 1);
      prev_sub = on_sub;
      if (cpu_ce) ce_cnt++;
      if (cpu_ce && !main_ready && !on_sub) early_ce++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset cpu_ce", cpu_ce, 0);
    chk("R9", "reset main_ready", main_ready, 0);
    chk("R9", "reset main_osc_en", main_osc_en, 1);
    chk("R9", "reset on_sub", on_sub, 0);
    chk("R9", "reset pcc_rd", pcc_rd, 0);
    chk("R9", "reset css_rd", css_rd, 0);
    rst_n = 1'b1;
    repeat (NSET + 50) @(negedge clk);
    chk("R1", "settled after wait", main_ready, 1);
    chk("R2", "strobes before settling", early_ce, 0);

    wr(1'b0, 8'h80);
    chk("R8", "stop refused on main", pcc_rd[7], 0);
    chk("R8", "oscillator still on", main_osc_en, 1);

    repeat (20) @(negedge clk);
    ce_cnt = 0;
    repeat (80) @(negedge clk);
    chk("R3", "slow strobes in 80 cycles", ce_cnt, 10);

    wr(1'b0, 8'h02);
    chk("R11", "speed bit readback", pcc_rd, 8'h02);
    repeat (20) @(negedge clk);
    ce_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R4", "fast strobes in 40 cycles", ce_cnt, 20);

    wr(1'b1, 8'h10);
    chk("R5", "sub select ignored when unsettled", css_rd, 8'h00);
    sub_ready = 1'b1;
    wr(1'b1, 8'h10);
    chk("R11", "source bit readback", css_rd, 8'h10);
    repeat (100) @(negedge clk);
    chk("R5", "running on subsystem", on_sub, 1);
    ce_cnt = 0;
    repeat (SUBP * 4) @(negedge clk);
    chk("R5", "sub strobes in four periods", ce_cnt, 4);

    wr(1'b0, 8'h82);
    chk("R6", "oscillator stopped", main_osc_en, 0);
    chk("R11", "stop bit readback", pcc_rd, 8'h82);
    @(negedge clk);
    chk("R6", "ready dropped", main_ready, 0);
    wr(1'b1, 8'h00);
    chk("R7", "main select ignored while stopped", css_rd, 8'h10);

    wr(1'b0, 8'h02);
    chk("R6", "oscillator restarted", main_osc_en, 1);
    repeat (100) @(negedge clk);
    wr(1'b1, 8'h00);
    chk("R7", "main select ignored while settling", css_rd, 8'h10);
    repeat (NSET) @(negedge clk);
    chk("R1", "resettled", main_ready, 1);
    wr(1'b1, 8'h00);
    chk("R7", "main select accepted", css_rd, 8'h00);
    repeat (100) @(negedge clk);
    chk("R10", "back on main", on_sub, 0);
    ce_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R4", "fast strobes after return", ce_cnt, 20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule